// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start-Bit Check

This block turns an asynchronous serial line into characters. It runs on a clock enable that pulses sixteen times per bit period, which baud logic outside the block supplies. A sampled falling edge on the line starts a candidate frame. The receiver counts half a bit and samples again. The frame goes ahead only if the line is still low at that centre point. A short low glitch on an idle line therefore never becomes a character.

After a valid start, the receiver takes each data bit, the parity bit when parity is on, and the first stop bit at the centre of its bit cell. The character width and the parity mode come from format inputs. When the stop bit has been sampled, the receiver issues a one-clock write strobe to the next stage, which can be a holding register or a FIFO. The strobe carries the character, a parity-error flag and a framing-error flag. The receiver keeps frame timing while the next stage is full or while reception is switched off, but it does not issue the strobe in either case.

Top module: `serial_rx_frontend`

## Requirements
- R1: While `rst_n` is low and after it is released, `wr_stb`, `wr_data`, `err_parity` and `err_frame` are 0, and the receiver is idle with the line taken as high.
- R2: A high-to-low change between two successive oversample ticks starts a candidate frame. The line is sampled again on the 8th tick after detection. If the line is high there, the receiver returns to idle, writes nothing and waits for a new falling edge.
- R3: Data bits arrive LSB first and are sampled every 16 ticks after the mid-start sample. `char_len` sets the number of data bits: 00=5, 01=6, 10=7, 11=8. Bits of `wr_data` above the character width are 0.
- R4: With `parity_on`=1, one parity bit follows the data. If `parity_stick`=0, the expected bit makes the count of ones odd when `parity_even`=0 and even when `parity_even`=1. If `parity_stick`=1, the expected bit is the inverse of `parity_even`. A mismatch sets `err_parity` with the character. With `parity_on`=0 there is no parity bit and `err_parity` is 0.
- R5: `err_frame` goes with the character and is 1 exactly when the stop-bit sample is low.
- R6: The stop bit is sampled on the 16th tick after the last data or parity sample. `wr_stb` rises for exactly one clock right after that sample, together with the character and its flags.
- R7: If `dst_full`=1 or `rx_en`=0 at the stop-bit sample, no write occurs. Frame timing continues regardless, so the next frame is received correctly.
- R8: After the stop sample the receiver waits for a new high-to-low change. A line held low after a stop bit does not start a frame until it has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable for writes |
| dst_full | input | 1 | Next stage cannot accept a character |
| char_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present |
| parity_even | input | 1 | Even parity select |
| parity_stick | input | 1 | Parity bit forced to a constant |
| wr_stb | output | 1 | One-clock character write strobe |
| wr_data | output | 8 | Received character |
| err_parity | output | 1 | Parity mismatch for this character |
| err_frame | output | 1 | Stop bit sampled low |

## Verification
The hardest situations to produce from the ports are a start that is dropped at mid-bit and a line that stays low after a stop bit that failed. Neither one produces an output event. The bench creates both on purpose. It drives a low pulse four ticks long on an idle line, and it holds the line low for several bit times after a frame whose stop bit is bad. Each of these is followed straight away by a normal frame. A receiver that did not re-arm correctly would then strobe a wrong character or miss the strobe, and the reference queue catches either.

// File: rtl/serial_rx_frontend.sv
module serial_rx_frontend #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       rx_en,
  input  logic       dst_full,
  input  logic [1:0] char_len,
  input  logic       parity_on,
  input  logic       parity_even,
  input  logic       parity_stick,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       err_parity,
  output logic       err_frame
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] PH_FULL = CW'(OVS - 1);
  localparam logic [CW-1:0] PH_HALF = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;
  logic rx_s, rx_prev, bad_par;
  logic [CW-1:0] ph;
  logic [2:0] bi;
  logic [7:0] sh;

  wire [2:0] last_bit = {1'b0, char_len} + 3'd4;
  wire exp_par = parity_stick ? ~parity_even : (parity_even ? ^sh : ~^sh);
  wire at_end = (ph == PH_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rx_s <= 1'b1; rx_prev <= 1'b1; ph <= '0; bi <= '0;
      sh <= '0; bad_par <= 1'b0; wr_stb <= 1'b0; wr_data <= '0;
      err_parity <= 1'b0; err_frame <= 1'b0;
    end else begin
      rx_s <= rx_in;
      wr_stb <= 1'b0;
      if (tick) begin
        rx_prev <= rx_s;
        case (st)
          S_IDLE: if (rx_prev && !rx_s) begin st <= S_START; ph <= '0; end
          S_START:
            if (ph == PH_HALF) begin
              ph <= '0;
              if (rx_s) st <= S_IDLE;
              else begin st <= S_DATA; bi <= '0; sh <= '0; bad_par <= 1'b0; end
            end else ph <= ph + 1'b1;
          S_DATA:
            if (at_end) begin
              ph <= '0;
              sh[bi] <= rx_s;
              if (bi == last_bit) st <= parity_on ? S_PAR : S_STOP;
              else bi <= bi + 1'b1;
            end else ph <= ph + 1'b1;
          S_PAR:
            if (at_end) begin
              ph <= '0; bad_par <= (rx_s != exp_par); st <= S_STOP;
            end else ph <= ph + 1'b1;
          S_STOP:
            if (at_end) begin
              ph <= '0; st <= S_IDLE;
              wr_stb <= rx_en && !dst_full;
              wr_data <= sh;
              err_parity <= parity_on && bad_par;
              err_frame <= !rx_s;
            end else ph <= ph + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_start_checked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_START) |-> !$past(rx_s));
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && char_len == 2'b00) |-> wr_data[7:5] == 3'b000);
  p_no_parity_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !$past(parity_on)) |-> !err_parity);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_write_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(rx_en && !dst_full && tick));
endmodule

// File: tb/tb_serial_rx_frontend.sv
module tb_serial_rx_frontend;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_in = 1'b1;
  logic rx_en = 1'b1, dst_full = 1'b0;
  logic [1:0] char_len = 2'b11;
  logic parity_on = 1'b0, parity_even = 1'b0, parity_stick = 1'b0;
  logic wr_stb, err_parity, err_frame;
  logic [7:0] wr_data;
  int checks = 0, errors = 0, cyc = 0, tcnt = 0;
  logic [9:0] expq[$];
  bit done = 0;

  serial_rx_frontend dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
    .rx_en(rx_en), .dst_full(dst_full), .char_len(char_len), .parity_on(parity_on),
    .parity_even(parity_even), .parity_stick(parity_stick), .wr_stb(wr_stb),
    .wr_data(wr_data), .err_parity(err_parity), .err_frame(err_frame));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick <= (tcnt == 3);
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: every clock, a strobe must match the oldest expected character
  always @(negedge clk) if (rst_n && !done) begin
    if (wr_stb) begin
      if (expq.size() == 0) check(0, "R7 unexpected write", wr_data, 0);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        check({err_frame, err_parity, wr_data} == e, "R3/R4/R5 character",
              {err_frame, err_parity, wr_data}, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_line(input bit v, input int nt);
    rx_in = v;
    repeat (nt) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit stop_v,
                            input bit expect_wr, input int trail_low);
    int n;
    logic [7:0] dm;
    logic pb;
    n = int'(char_len) + 5;
    dm = d & 8'((1 << n) - 1);
    pb = parity_stick ? ~parity_even : (parity_even ? ^dm : ~^dm);
    pb = pb ^ flip_par;
    if (expect_wr) expq.push_back({~stop_v, parity_on & flip_par, dm});
    hold_line(1'b0, 16);
    for (int i = 0; i < n; i++) hold_line(dm[i], 16);
    if (parity_on) hold_line(pb, 16);
    hold_line(stop_v, 16);
    check(expq.size() == 0, "R6 write after stop sample", expq.size(), 0);
    if (trail_low > 0) hold_line(1'b0, trail_low * 16);
    hold_line(1'b1, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wr_stb == 0 && wr_data == 0, "R1 reset outputs", {wr_stb, wr_data}, 0);
    check(err_parity == 0 && err_frame == 0, "R1 reset flags", {err_parity, err_frame}, 0);
    rst_n = 1'b1;
    hold_line(1'b1, 20);
    check(wr_stb == 0, "R1 idle after reset", wr_stb, 0);

    // R3 R6: eight data bits, no parity
    send_frame(8'hA5, 0, 1, 1, 0);
    send_frame(8'h3C, 0, 1, 1, 0);
    // R3: narrower characters
    char_len = 2'b00; send_frame(8'hF5, 0, 1, 1, 0);
    char_len = 2'b01; send_frame(8'hEA, 0, 1, 1, 0);
    char_len = 2'b10; send_frame(8'h81, 0, 1, 1, 0);
    // R4: parity modes
    char_len = 2'b11; parity_on = 1;
    parity_even = 1; send_frame(8'h37, 0, 1, 1, 0); send_frame(8'h37, 1, 1, 1, 0);
    parity_even = 0; send_frame(8'h5A, 0, 1, 1, 0); send_frame(8'h5B, 1, 1, 1, 0);
    parity_stick = 1; send_frame(8'h12, 0, 1, 1, 0); send_frame(8'h12, 1, 1, 1, 0);
    parity_even = 1; send_frame(8'hFE, 1, 1, 1, 0);
    parity_stick = 0; parity_on = 0;
    // R5: framing error
    send_frame(8'h66, 0, 0, 1, 0);
    // R2: low glitch shorter than half a bit, then a normal frame
    hold_line(1'b0, 4); hold_line(1'b1, 30);
    check(expq.size() == 0, "R2 glitch rejected", expq.size(), 0);
    send_frame(8'hC3, 0, 1, 1, 0);
    // R7: full and disabled drop the character but keep framing
    dst_full = 1; send_frame(8'h99, 0, 1, 0, 0);
    dst_full = 0; send_frame(8'h42, 0, 1, 1, 0);
    rx_en = 0; send_frame(8'h17, 0, 1, 0, 0);
    rx_en = 1; send_frame(8'hE8, 0, 1, 1, 0);
    // R8: line held low after a bad stop, then a good frame
    send_frame(8'h00, 0, 0, 1, 3);
    check(expq.size() == 0, "R8 no frame from held low line", expq.size(), 0);
    send_frame(8'h5D, 0, 1, 1, 0);
    hold_line(1'b1, 20);
    check(expq.size() == 0, "R6 all writes seen", expq.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule